// File: doc/BRIEF.md
# Two-Wire Block Protection and Bank Select Responder

This block is the slave front end of a two-wire serial bus for a presence-detect memory. The memory has four protectable blocks and two storage banks. It watches SCL and SDA, finds START and STOP conditions and shifts in a command byte, then a dummy address byte and a dummy data byte. The result of a command is carried by the acknowledge pattern. On each acknowledge slot the block either pulls SDA low (ACK) or leaves it released (NoACK).

The block holds four protection flags and a one-bit bank register. Three kinds of command change them: set protection on one block, clear every flag, and select a bank. Two kinds of command only report state through ACK or NoACK: a query of one block's flag and a query of the active bank. After a query the slave leaves the line released while the master clocks dummy bytes. A one-clock write-cycle strobe tells the storage side to commit a change in protection.

Top module: `spd_prot_responder`

## Requirements
- R1: A command byte has the form bits 7:4 = 0110, bits 3:1 = operation code, bit 0 = 1 for a query and 0 otherwise. A byte with a different upper nibble is NoACKed, and so are its later bytes. The same holds for operation 5 in either direction and for a query with operation 4. None of these changes state or strobes.
- R2: A set command (operation b in 0..3, byte 0x60+2b) on an unprotected block b is ACKed on the command, address and data bytes. At the following STOP, wr_cycle_o is high for exactly one clock and prot_o[b] becomes 1.
- R3: A set command on a block already protected is NoACKed on all three bytes. It gives no strobe and prot_o does not change.
- R4: The clear command (byte 0x68) is ACKed on all three bytes whatever the protection state. At STOP it gives one strobe, and prot_o becomes all zero.
- R5: A block query (byte 0x61+2b) is ACKed exactly when prot_o[b] is 0. The dummy bytes that follow read as 0xFF. After the master's NoACK and a STOP, the slave is idle.
- R6: A bank select (byte 0x6C for bank 0, 0x6E for bank 1; command bit 1 is the bank) is ACKed on the command and address bytes and NoACKed on the data byte. bank_o then takes the bank, and no strobe follows.
- R7: After reset, prot_o, bank_o, sda_oe_o and wr_cycle_o are all 0.
- R8: The bank query (byte 0x6D) is ACKed when bank_o is 0 and NoACKed when it is 1.
- R9: A STOP that comes before the data-byte acknowledge slot has finished gives no strobe and leaves prot_o unchanged.
- R10: A repeated START drops the command in progress without changing prot_o or bank_o. The command that follows it in the same transaction is decoded normally.
- R11: sda_oe_o changes only in response to an SCL falling edge, a START or a STOP. It is released at the end of every acknowledge slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | Pull SDA low when 1 (ACK); released when 0 |
| wr_cycle_o | output | 1 | One-clock strobe committing a protection change |
| prot_o | output | 4 | Protection flag per block |
| bank_o | output | 1 | Active bank, 0 lower, 1 upper |

## Verification
Two events can fall in the same clock. A STOP can land while a protection commit is armed, and the flag update and strobe then happen in the very cycle the STOP is seen. A repeated START can also land right after a fully ACKed data slot, and it must cancel that armed commit. The bench provokes the first case for every one of the sixteen protection patterns and judges it by the strobe count and prot_o after the STOP. It provokes the second by sending a repeated START after the data acknowledge and then a query in the same transaction. That case must give no strobe, leave prot_o unchanged and still ACK the query.

// File: rtl/spd_resp_pkg.sv
package spd_resp_pkg;
  localparam int unsigned NUM_BLK    = 4;
  localparam int unsigned BLK_W      = $clog2(NUM_BLK);
  localparam int unsigned BYTE_BITS  = 8;
  localparam logic [3:0]  PREAMBLE   = 4'b0110;

  localparam logic [2:0] OP_CLR = 3'd4;
  localparam logic [2:0] OP_RSV = 3'd5;

  typedef struct packed {
    logic [3:0] pre;
    logic [2:0] op;
    logic       rd;
  } cmd_t;
endpackage

// File: rtl/spd_line_sync.sv
module spd_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sr, sda_sr;
  logic scl_q, sda_q, scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s      = scl_sr[STAGES-1];
  assign sda_s      = sda_sr[STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/spd_bit_engine.sv
module spd_bit_engine
  import spd_resp_pkg::*;
#(
  parameter int unsigned BITS = BYTE_BITS
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic            rise_i,
  input  logic            fall_i,
  input  logic            sda_i,
  output logic [BITS-1:0] byte_o,
  output logic            byte_rdy_o,
  output logic            slot_end_o,
  output logic [1:0]      idx_o
);
  localparam int unsigned CNT_W = $clog2(BITS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BITS);

  logic             active_q, in_slot_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      in_slot_q  <= 1'b0;
      cnt_q      <= '0;
      byte_o     <= '0;
      byte_rdy_o <= 1'b0;
      slot_end_o <= 1'b0;
      idx_o      <= '0;
    end else begin
      byte_rdy_o <= 1'b0;
      slot_end_o <= 1'b0;
      if (start_i || stop_i) begin
        active_q  <= start_i;
        in_slot_q <= 1'b0;
        cnt_q     <= '0;
        idx_o     <= '0;
      end else if (active_q) begin
        if (rise_i && cnt_q < CNT_FULL) begin
          byte_o <= {byte_o[BITS-2:0], sda_i};
          cnt_q  <= cnt_q + 1'b1;
        end
        if (fall_i) begin
          if (cnt_q == CNT_FULL && !in_slot_q) begin
            in_slot_q  <= 1'b1;
            byte_rdy_o <= 1'b1;
          end else if (in_slot_q) begin
            in_slot_q  <= 1'b0;
            cnt_q      <= '0;
            slot_end_o <= 1'b1;
            if (idx_o != 2'd3) idx_o <= idx_o + 1'b1;  // saturates: 3 means "past data byte"
          end
        end
      end
    end
  end
endmodule

// File: rtl/spd_cmd_ctrl.sv
module spd_cmd_ctrl
  import spd_resp_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               byte_rdy_i,
  input  logic               slot_end_i,
  input  logic [7:0]         byte_i,
  input  logic [1:0]         idx_i,
  output logic               sda_oe_o,
  output logic               wr_cycle_o,
  output logic [NUM_BLK-1:0] prot_o,
  output logic               bank_o
);
  cmd_t cmd_now, cmd_q;
  logic acc_q, ack_q, armed_q;
  logic ack_cmd, ack_now, setclr_q, sel_q;
  logic [BLK_W-1:0] blk_now, blk_q;

  assign cmd_now  = cmd_t'(byte_i);
  assign blk_now  = cmd_now.op[BLK_W-1:0];
  assign blk_q    = cmd_q.op[BLK_W-1:0];
  assign setclr_q = !cmd_q.rd && (!cmd_q.op[2] || cmd_q.op == OP_CLR);
  assign sel_q    = !cmd_q.rd && cmd_q.op[2:1] == 2'b11;

  always_comb begin
    ack_cmd = 1'b0;
    if (cmd_now.pre == PREAMBLE) begin
      if (!cmd_now.op[2])            ack_cmd = !prot_o[blk_now];
      else if (cmd_now.op[1])        ack_cmd = cmd_now.rd ? !bank_o : 1'b1;
      else if (cmd_now.op != OP_RSV) ack_cmd = !cmd_now.rd;
    end
  end

  always_comb begin
    unique case (idx_i)
      2'd0:    ack_now = ack_cmd;
      2'd1:    ack_now = acc_q && !cmd_q.rd;
      2'd2:    ack_now = acc_q && setclr_q;
      default: ack_now = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q      <= '0;
      acc_q      <= 1'b0;
      ack_q      <= 1'b0;
      armed_q    <= 1'b0;
      sda_oe_o   <= 1'b0;
      wr_cycle_o <= 1'b0;
      prot_o     <= '0;
      bank_o     <= 1'b0;
    end else begin
      wr_cycle_o <= 1'b0;
      if (start_i || stop_i) begin
        sda_oe_o <= 1'b0;
        acc_q    <= 1'b0;
        ack_q    <= 1'b0;
        armed_q  <= 1'b0;
        if (stop_i && armed_q) begin
          wr_cycle_o <= 1'b1;
          if (cmd_q.op == OP_CLR) prot_o <= '0;
          else                    prot_o[blk_q] <= 1'b1;
        end
      end else begin
        if (byte_rdy_i) begin
          sda_oe_o <= ack_now;
          ack_q    <= ack_now;
          if (idx_i == 2'd0) begin
            cmd_q <= cmd_now;
            acc_q <= ack_cmd;
          end
          if (idx_i == 2'd2 && acc_q && sel_q) bank_o <= cmd_q.op[0];
        end
        if (slot_end_i) begin
          sda_oe_o <= 1'b0;
          // idx already advanced: 3 means the data byte slot just closed
          if (idx_i == 2'd3 && ack_q && setclr_q) armed_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spd_prot_responder.sv
module spd_prot_responder
  import spd_resp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  output logic               wr_cycle_o,
  output logic [NUM_BLK-1:0] prot_o,
  output logic               bank_o
);
  logic sda_w, scl_rise_w, scl_fall_w, start_w, stop_w;
  logic byte_rdy_w, slot_end_w;
  logic [BYTE_BITS-1:0] byte_w;
  logic [1:0] idx_w;

  spd_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_w), .scl_rise_o(scl_rise_w), .scl_fall_o(scl_fall_w),
    .start_o(start_w), .stop_o(stop_w)
  );

  spd_bit_engine #(.BITS(BYTE_BITS)) i_bits (
    .clk_i, .rst_ni, .start_i(start_w), .stop_i(stop_w),
    .rise_i(scl_rise_w), .fall_i(scl_fall_w), .sda_i(sda_w),
    .byte_o(byte_w), .byte_rdy_o(byte_rdy_w), .slot_end_o(slot_end_w),
    .idx_o(idx_w)
  );

  spd_cmd_ctrl i_ctrl (
    .clk_i, .rst_ni, .start_i(start_w), .stop_i(stop_w),
    .byte_rdy_i(byte_rdy_w), .slot_end_i(slot_end_w),
    .byte_i(byte_w), .idx_i(idx_w),
    .sda_oe_o, .wr_cycle_o, .prot_o, .bank_o
  );
endmodule

// File: rtl/spd_prot_responder_chk.sv
module spd_prot_responder_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_fall_i,
  input logic       start_i,
  input logic       stop_i,
  input logic       byte_rdy_i,
  input logic       sda_oe_i,
  input logic       wr_cycle_i,
  input logic [3:0] prot_i,
  input logic       bank_i
);
  p_wr_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cycle_i |=> !wr_cycle_i);

  p_wr_at_stop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cycle_i |-> $past(stop_i));

  p_prot_with_wr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(prot_i) |-> wr_cycle_i);

  p_bank_after_byte_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bank_i) |-> $past(byte_rdy_i));

  p_oe_drop_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !sda_oe_i);

  p_oe_timing_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_i) |-> ($past(scl_fall_i, 2) || $past(start_i) || $past(stop_i)));
endmodule

bind spd_prot_responder spd_prot_responder_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_fall_i(scl_fall_w), .start_i(start_w),
  .stop_i(stop_w), .byte_rdy_i(byte_rdy_w), .sda_oe_i(sda_oe_o),
  .wr_cycle_i(wr_cycle_o), .prot_i(prot_o), .bank_i(bank_o)
);

// File: tb/test_spd_prot_responder.sv
`timescale 1ns/1ps
module test_spd_prot_responder;
  localparam int Q = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe_o, wr_cycle_o, bank_o, sda_bus;
  logic [3:0] prot_o;
  int total = 0, bad = 0, wr_cnt = 0;

  always #5 clk_i = ~clk_i;
  assign sda_bus = m_sda & ~sda_oe_o;

  spd_prot_responder i_spd_prot_responder (
    .clk_i, .rst_ni, .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe_o, .wr_cycle_o, .prot_o, .bank_o
  );

  always @(posedge clk_i) if (rst_ni && wr_cycle_o) wr_cnt <= wr_cnt + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; hold(Q); m_scl = 1'b1; hold(Q);
    m_sda = 1'b0; hold(Q); m_scl = 1'b0; hold(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hold(Q); m_scl = 1'b1; hold(Q);
    m_sda = 1'b1; hold(2*Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hold(Q); m_scl = 1'b1; hold(2*Q); m_scl = 1'b0; hold(Q);
    end
    m_sda = 1'b1; hold(Q); m_scl = 1'b1; hold(Q);
    ack = ~sda_bus;
    hold(Q); m_scl = 1'b0; hold(Q);
  endtask

  task automatic get_byte(output logic [7:0] d);
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      hold(Q); m_scl = 1'b1; hold(Q); d = {d[6:0], sda_bus}; hold(Q); m_scl = 1'b0;
    end
    hold(Q); m_scl = 1'b1; hold(2*Q); m_scl = 1'b0; hold(Q);  // master NoACK
  endtask

  // full three-byte write transaction; exp bit0 cmd, bit1 addr, bit2 data
  task automatic wr_seq(input logic [7:0] cmd, input logic [2:0] exp, input string tag);
    logic a;
    bus_start();
    put_byte(cmd, a);   chk(a == exp[0], {tag, " cmd ack"}, a, exp[0]);
    put_byte(8'h00, a); chk(a == exp[1], {tag, " addr ack"}, a, exp[1]);
    put_byte(8'h00, a); chk(a == exp[2], {tag, " data ack"}, a, exp[2]);
    bus_stop();
  endtask

  task automatic query(input logic [7:0] cmd, input logic exp, input string tag, input bit read_dummy);
    logic a;
    logic [7:0] d;
    bus_start();
    put_byte(cmd, a);
    chk(a == exp, {tag, " query ack"}, a, exp);
    if (read_dummy) begin
      get_byte(d);
      chk(d == 8'hFF, {tag, " dummy byte released"}, d, 8'hFF);
    end
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL R1 watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int w0;
    logic a;
    hold(5);
    chk(prot_o == 4'h0 && bank_o == 1'b0 && sda_oe_o == 1'b0 && wr_cycle_o == 1'b0,
        "R7 reset state", {prot_o, bank_o, sda_oe_o, wr_cycle_o}, 0);
    rst_ni = 1'b1;
    hold(5);
    chk(prot_o == 4'h0 && bank_o == 1'b0, "R7 after release", {prot_o, bank_o}, 0);
    query(8'h6D, 1'b1, "R8 bank0", 1'b1);

    // sweep every protection pattern
    for (int p = 0; p < 16; p++) begin
      w0 = wr_cnt;
      wr_seq(8'h68, 3'b111, "R4 clear");
      chk(wr_cnt == w0 + 1, "R4 strobe", wr_cnt - w0, 1);
      chk(prot_o == 4'h0, "R4 flags cleared", prot_o, 0);
      for (int b = 0; b < 4; b++) if (p[b]) begin
        w0 = wr_cnt;
        wr_seq(8'h60 + 8'(2*b), 3'b111, "R2 set");
        chk(wr_cnt == w0 + 1, "R2 strobe", wr_cnt - w0, 1);
        chk(prot_o[b] == 1'b1, "R2 flag set", prot_o, b);
      end
      chk(prot_o == 4'(p), "R2 pattern", prot_o, p);
      for (int b = 0; b < 4; b++)
        query(8'h61 + 8'(2*b), ~p[b], "R5 block", b[0]);
      for (int b = 0; b < 4; b++) if (p[b]) begin
        w0 = wr_cnt;
        wr_seq(8'h60 + 8'(2*b), 3'b000, "R3 reset-again");
        chk(wr_cnt == w0 && prot_o == 4'(p), "R3 no change", {wr_cnt - w0, prot_o}, p);
      end
    end

    wr_seq(8'h68, 3'b111, "R4 clear");
    // invalid commands
    w0 = wr_cnt;
    wr_seq(8'hA0, 3'b000, "R1 bad preamble");
    wr_seq(8'h70, 3'b000, "R1 bad preamble");
    wr_seq(8'h6A, 3'b000, "R1 reserved op");
    query(8'h69, 1'b0, "R1 read of clear op", 1'b0);
    query(8'h6B, 1'b0, "R1 reserved read", 1'b0);
    chk(wr_cnt == w0 && prot_o == 4'h0 && bank_o == 1'b0, "R1 no effect",
        {wr_cnt - w0, prot_o, bank_o}, 0);

    // bank select
    w0 = wr_cnt;
    wr_seq(8'h6E, 3'b011, "R6 select1");
    chk(bank_o == 1'b1 && wr_cnt == w0, "R6 bank1 no strobe", {bank_o, wr_cnt - w0}, 2);
    query(8'h6D, 1'b0, "R8 bank1", 1'b1);
    wr_seq(8'h6C, 3'b011, "R6 select0");
    chk(bank_o == 1'b0 && wr_cnt == w0, "R6 bank0 no strobe", {bank_o, wr_cnt - w0}, 0);
    query(8'h6D, 1'b1, "R8 bank0 again", 1'b0);

    // early STOP aborts
    w0 = wr_cnt;
    bus_start(); put_byte(8'h62, a); put_byte(8'h00, a); bus_stop();
    chk(wr_cnt == w0 && prot_o == 4'h0, "R9 stop after addr", {wr_cnt - w0, prot_o}, 0);
    bus_start(); put_byte(8'h64, a); bus_stop();
    chk(wr_cnt == w0 && prot_o == 4'h0, "R9 stop after cmd", {wr_cnt - w0, prot_o}, 0);

    // repeated START after fully acked data byte, then a query
    bus_start(); put_byte(8'h66, a); put_byte(8'h00, a); put_byte(8'h00, a);
    chk(a == 1'b1, "R10 data acked before restart", a, 1);
    bus_start(); put_byte(8'h67, a);
    chk(a == 1'b1, "R10 query after restart", a, 1);
    bus_stop();
    chk(wr_cnt == w0 && prot_o == 4'h0, "R10 no commit", {wr_cnt - w0, prot_o}, 0);
    // repeated START inside bank select
    bus_start(); put_byte(8'h6E, a); put_byte(8'h00, a);
    bus_start(); put_byte(8'h6D, a);
    chk(a == 1'b1, "R10 bank query after restart", a, 1);
    bus_stop();
    chk(bank_o == 1'b0, "R10 bank unchanged", bank_o, 0);
    chk(sda_oe_o == 1'b0, "R11 released at idle", sda_oe_o, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule